// File: doc/BRIEF.md
# Extended Match Channel Timer

This block holds eight match channels, indexed 0 to 7. Each channel has a 32-bit counter, a 32-bit match value and a 10-bit control word. Each counter advances on the cycles where its chosen rate-enable input is high. A channel either compares its own counter against its match value, or follows the counter of its group leader. Channels 0–3 follow counter 0, channels 4–5 follow counter 4, and channels 6–7 follow counter 6. A channel whose match fires can set its status bit, which feeds one shared interrupt line.

Software reaches the counters, match values, control words and a snapshot register through a simple word-addressed register port. The block takes the interrupt-enable mask and the status clear strobes from elsewhere. A match can clear the channel's own counter. A match can also re-arm for periodic operation or fire only once. Reading counter 5 or counter 7 with capture enabled copies the neighbouring leader counter (4 or 6) into the snapshot register.

Register offsets are: snapshot 0x20, counter i at 0x40+4i, match i at 0x80+4i, control i at 0xC0+4i. Control word fields are:
- [2:0] rate select
- [3] clear-on-match
- [6] periodic
- [7] own-counter
- [8] rate block (channels 4–7 only)
- [9] snapshot capture (channels 4–7 only)

Top module: `xmatch_timer`

## Requirements
- R1: After synchronous reset, every counter, match value, control word, the snapshot and all status bits read 0, and irq_o is low.
- R2: A running counter adds 1 (wrapping at 2^32) on each cycle where its selected rate input is high. Rate codes 1–5 pick tick_en_i[0]–tick_en_i[4]. Codes 0, 6 and 7 hold the counter.
- R3: A register write to counter i (0x40+4i) loads the written value, readable in the next cycle.
- R4: Control words of channels 0–3 keep only bits [7:0]. Those of channels 4–7 keep bits [9:0]. On channels 4–7, bit 8 stops the counter whatever the rate code.
- R5: With control bit 7 clear, a channel compares against its group leader's counter. If it is not a leader (0, 4, 6), its own counter stays stopped.
- R6: A match fires when the compared counter ticks onto the match value. It sets status bit i only if irq_en_i[i] is high, and irq_o is high while any status bit is set.
- R7: With control bit 3 set, a match clears the channel's own counter to 0 instead of leaving the match value.
- R8: With control bit 6 clear, a channel fires once and then stays silent. With bit 6 set, it fires on every later match.
- R9: status_clr_i[i] clears status bit i. irq_o drops only once no status bit remains set.
- R10: Reading counter 5 (or 7) while that channel's bit 9 is set copies counter 4 (or 6) into the snapshot register at 0x20. Without bit 9 the snapshot is unchanged.
- R11: Writing a channel's match value or control word re-arms a one-shot channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en_i | input | 5 | Rate-enable pulses, one per selectable rate |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (drives snapshot capture) |
| reg_addr_i | input | 8 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational from the address |
| irq_en_i | input | 8 | Per-channel status enable mask |
| status_clr_i | input | 8 | Per-channel status clear strobes |
| status_o | output | 8 | Per-channel match status |
| irq_o | output | 1 | Shared interrupt, high while any status bit is set |

## Verification
A wrong counter or wrong rate selection shows up on the next read of that counter, and the random rate patterns are checked against a counted model. A wrong arm state or wrong group routing shows on status_o in the same cycle the expected match tick lands, or as a status bit that rises one pass too late or too early. Snapshot faults show on the read of offset 0x20 right after the triggering counter read.

// File: rtl/xmt_pkg.sv
`timescale 1ns/1ps
package xmt_pkg;
    localparam int NCH   = 8;
    localparam int NTICK = 5;
    localparam int CTRLW = 10;
    localparam int IDXW  = $clog2(NCH);

    typedef enum logic [2:0] {
        RK_NONE, RK_SNAP, RK_CNT, RK_MATCH, RK_CTRL
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e        kind;
        logic [IDXW-1:0]  idx;
    } reg_sel_t;

    typedef struct packed {
        logic       snap_en;
        logic       rate_block;
        logic       own_cnt;
        logic       periodic;
        logic [1:0] spare;
        logic       clr_on_match;
        logic [2:0] rate_sel;
    } ctrl_t;

    function automatic reg_sel_t decode(input logic [7:0] a);
        reg_sel_t r;
        r.kind = RK_NONE;
        r.idx  = a[IDXW+1:2];
        if (a[1:0] == 2'b00) begin
            if (a == 8'h20)             r.kind = RK_SNAP;
            else if (a[7:5] == 3'b010)  r.kind = RK_CNT;
            else if (a[7:5] == 3'b100)  r.kind = RK_MATCH;
            else if (a[7:5] == 3'b110)  r.kind = RK_CTRL;
        end
        return r;
    endfunction

    function automatic int group_leader(input int ch);
        if (ch < NCH/2)       return 0;
        if (ch < 3*NCH/4)     return NCH/2;
        return 3*NCH/4;
    endfunction

    function automatic logic is_upper(input int ch);
        return ch >= NCH/2;
    endfunction

    function automatic logic is_snap_reader(input int ch);
        return is_upper(ch) && (ch % 2 == 1);
    endfunction

    function automatic logic [CTRLW-1:0] keep_mask(input int ch);
        return is_upper(ch) ? {CTRLW{1'b1}} : CTRLW'(8'hFF);
    endfunction

    function automatic logic pick_tick(input logic [2:0] code,
                                       input logic [NTICK-1:0] ticks);
        logic t;
        t = 1'b0;
        for (int i = 0; i < NTICK; i++)
            if (code == 3'(i + 1)) t = ticks[i];
        return t;
    endfunction
endpackage

// File: rtl/xmt_counter.sv
`timescale 1ns/1ps
module xmt_counter #(
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load_i,
    input  logic [CW-1:0] load_val_i,
    input  logic          clr_i,
    input  logic          tick_i,
    output logic [CW-1:0] cnt_o
);
    always_ff @(posedge clk) begin
        if (rst)          cnt_o <= '0;
        else if (load_i)  cnt_o <= load_val_i;
        else if (clr_i)   cnt_o <= '0;
        else if (tick_i)  cnt_o <= cnt_o + CW'(1);
    end
endmodule

// File: rtl/xmt_compare.sv
`timescale 1ns/1ps
module xmt_compare #(
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] src_cnt_i,
    input  logic          src_tick_i,
    input  logic          src_load_i,
    input  logic [CW-1:0] match_i,
    input  logic          rearm_i,
    input  logic          periodic_i,
    output logic          hit_o
);
    logic armed_q;

    // fires on the tick that carries the source counter onto the match value
    assign hit_o = armed_q && src_tick_i && !src_load_i
                   && ((src_cnt_i + CW'(1)) == match_i);

    always_ff @(posedge clk) begin
        if (rst)                       armed_q <= 1'b1;
        else if (rearm_i)              armed_q <= 1'b1;
        else if (hit_o && !periodic_i) armed_q <= 1'b0;
    end
endmodule

// File: rtl/xmt_status.sv
`timescale 1ns/1ps
module xmt_status #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] en_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] status_o,
    output logic         irq_o
);
    always_ff @(posedge clk) begin
        if (rst) status_o <= '0;
        else     status_o <= (status_o & ~clr_i) | (set_i & en_i);
    end

    assign irq_o = |status_o;
endmodule

// File: rtl/xmatch_timer.sv
`timescale 1ns/1ps
module xmatch_timer
    import xmt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NTICK-1:0]  tick_en_i,
    input  logic              reg_wr_i,
    input  logic              reg_rd_i,
    input  logic [7:0]        reg_addr_i,
    input  logic [CNT_W-1:0]  reg_wdata_i,
    output logic [CNT_W-1:0]  reg_rdata_o,
    input  logic [NCH-1:0]    irq_en_i,
    input  logic [NCH-1:0]    status_clr_i,
    output logic [NCH-1:0]    status_o,
    output logic              irq_o
);
    reg_sel_t              sel;
    logic [NCH-1:0]        wr_cnt, wr_match, wr_ctrl;
    ctrl_t                 ctrl_q  [NCH];
    logic [CNT_W-1:0]      match_q [NCH];
    logic [CNT_W-1:0]      cnt_a   [NCH];
    logic [NCH-1:0][CNT_W-1:0] cnt_flat;
    logic [2:0]            rate_eff [NCH];
    logic [NCH-1:0]        own_tick, own_clr, src_tick, src_load, hit;
    logic [CNT_W-1:0]      src_cnt [NCH];
    logic [CNT_W-1:0]      snap_q, snap_val;
    logic                  snap_take;

    assign sel = decode(reg_addr_i);

    always_comb begin
        for (int k = 0; k < NCH; k++) begin
            wr_cnt[k]   = reg_wr_i && sel.kind == RK_CNT   && sel.idx == IDXW'(k);
            wr_match[k] = reg_wr_i && sel.kind == RK_MATCH && sel.idx == IDXW'(k);
            wr_ctrl[k]  = reg_wr_i && sel.kind == RK_CTRL  && sel.idx == IDXW'(k);
        end
    end

    // per-channel rate resolution and compare-source routing
    always_comb begin
        for (int k = 0; k < NCH; k++) begin
            rate_eff[k] = (is_upper(k) && ctrl_q[k].rate_block) ? 3'd0 : ctrl_q[k].rate_sel;
            own_tick[k] = (ctrl_q[k].own_cnt || group_leader(k) == k)
                          && pick_tick(rate_eff[k], tick_en_i);
            own_clr[k]  = hit[k] && ctrl_q[k].clr_on_match;
        end
        for (int k = 0; k < NCH; k++) begin
            if (ctrl_q[k].own_cnt) begin
                src_cnt[k]  = cnt_a[k];
                src_tick[k] = own_tick[k];
                src_load[k] = wr_cnt[k];
            end else begin
                src_cnt[k]  = cnt_a[group_leader(k)];
                src_tick[k] = own_tick[group_leader(k)];
                src_load[k] = wr_cnt[group_leader(k)];
            end
            cnt_flat[k] = cnt_a[k];
        end
    end

    for (genvar k = 0; k < NCH; k++) begin : g_ch
        xmt_counter #(.CW(CNT_W)) cnt_i (
            .clk        (clk),
            .rst        (rst),
            .load_i     (wr_cnt[k]),
            .load_val_i (reg_wdata_i),
            .clr_i      (own_clr[k]),
            .tick_i     (own_tick[k]),
            .cnt_o      (cnt_a[k])
        );
        xmt_compare #(.CW(CNT_W)) cmp_i (
            .clk        (clk),
            .rst        (rst),
            .src_cnt_i  (src_cnt[k]),
            .src_tick_i (src_tick[k]),
            .src_load_i (src_load[k]),
            .match_i    (match_q[k]),
            .rearm_i    (wr_match[k] | wr_ctrl[k]),
            .periodic_i (ctrl_q[k].periodic),
            .hit_o      (hit[k])
        );
    end

    xmt_status #(.N(NCH)) stat_i (
        .clk      (clk),
        .rst      (rst),
        .set_i    (hit),
        .en_i     (irq_en_i),
        .clr_i    (status_clr_i),
        .status_o (status_o),
        .irq_o    (irq_o)
    );

    // snapshot: a read of an odd upper counter captures its left neighbour
    assign snap_take = reg_rd_i && sel.kind == RK_CNT
                       && is_snap_reader(int'(sel.idx)) && ctrl_q[sel.idx].snap_en;
    assign snap_val  = cnt_a[sel.idx - IDXW'(1)];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < NCH; k++) begin
                ctrl_q[k]  <= '0;
                match_q[k] <= '0;
            end
            snap_q <= '0;
        end else begin
            for (int k = 0; k < NCH; k++) begin
                if (wr_ctrl[k])  ctrl_q[k]  <= ctrl_t'(reg_wdata_i[CTRLW-1:0] & keep_mask(k));
                if (wr_match[k]) match_q[k] <= reg_wdata_i;
            end
            if (snap_take) snap_q <= snap_val;
        end
    end

    always_comb begin
        case (sel.kind)
            RK_SNAP:  reg_rdata_o = snap_q;
            RK_CNT:   reg_rdata_o = cnt_a[sel.idx];
            RK_MATCH: reg_rdata_o = match_q[sel.idx];
            RK_CTRL:  reg_rdata_o = CNT_W'(ctrl_q[sel.idx]);
            default:  reg_rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/xmt_checker.sv
`timescale 1ns/1ps
module xmt_checker
    import xmt_pkg::*;
#(
    parameter int CW = 32
) (
    input logic                    clk,
    input logic                    rst,
    input logic [NTICK-1:0]        tick_en_i,
    input logic                    reg_wr_i,
    input logic                    reg_rd_i,
    input logic [NCH-1:0]          irq_en_i,
    input logic [NCH-1:0]          status_clr_i,
    input logic [NCH-1:0]          status_o,
    input logic                    irq_o,
    input logic [NCH-1:0][CW-1:0]  cnt,
    input logic [CW-1:0]           snap
);
    a_r1_quiet_after_reset: assert property (@(posedge clk)
        $past(rst) |-> (status_o == '0 && !irq_o));

    for (genvar k = 0; k < NCH; k++) begin : g_k
        a_r2_step_or_clear: assert property (@(posedge clk) disable iff (rst)
            !$past(reg_wr_i) |-> (cnt[k] == $past(cnt[k])
                                  || cnt[k] == $past(cnt[k]) + CW'(1)
                                  || cnt[k] == '0));
        a_r2_hold_without_tick: assert property (@(posedge clk) disable iff (rst)
            (!$past(reg_wr_i) && $past(tick_en_i) == '0) |-> cnt[k] == $past(cnt[k]));
    end

    a_r6_set_needs_enable: assert property (@(posedge clk) disable iff (rst)
        (status_o & ~$past(status_o) & ~$past(irq_en_i)) == '0);

    a_r6_irq_when_pending: assert property (@(posedge clk) disable iff (rst)
        status_o != '0 |-> irq_o);

    a_r9_irq_low_when_idle: assert property (@(posedge clk) disable iff (rst)
        status_o == '0 |-> !irq_o);

    a_r9_fall_only_on_clear: assert property (@(posedge clk) disable iff (rst)
        ($past(status_o) & ~status_o & ~$past(status_clr_i)) == '0);

    a_r10_snap_only_on_read: assert property (@(posedge clk) disable iff (rst)
        !$past(reg_rd_i) |-> $stable(snap));
endmodule

bind xmatch_timer xmt_checker #(.CW(CNT_W)) chk_i (
    .clk          (clk),
    .rst          (rst),
    .tick_en_i    (tick_en_i),
    .reg_wr_i     (reg_wr_i),
    .reg_rd_i     (reg_rd_i),
    .irq_en_i     (irq_en_i),
    .status_clr_i (status_clr_i),
    .status_o     (status_o),
    .irq_o        (irq_o),
    .cnt          (cnt_flat),
    .snap         (snap_q)
);

// File: tb/xmatch_timer_tb_top.sv
`timescale 1ns/1ps
module xmatch_timer_tb_top;
    import xmt_pkg::*;
    localparam int CW = 32;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [NTICK-1:0] tick_en = '0;
    logic reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0] reg_addr = '0;
    logic [CW-1:0] reg_wdata = '0, reg_rdata;
    logic [NCH-1:0] irq_en = '0, status_clr = '0, status;
    logic irq;
    int n_cmp = 0, n_bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    xmatch_timer #(.CNT_W(CW)) dut_i (
        .clk(clk), .rst(rst), .tick_en_i(tick_en),
        .reg_wr_i(reg_wr), .reg_rd_i(reg_rd), .reg_addr_i(reg_addr),
        .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
        .irq_en_i(irq_en), .status_clr_i(status_clr),
        .status_o(status), .irq_o(irq)
    );

    function automatic logic [7:0] a_cnt(int i);   return 8'(8'h40 + 4*i); endfunction
    function automatic logic [7:0] a_match(int i); return 8'(8'h80 + 4*i); endfunction
    function automatic logic [7:0] a_ctrl(int i);  return 8'(8'hC0 + 4*i); endfunction

    task automatic check(string req, logic [CW-1:0] act, logic [CW-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [CW-1:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, output logic [CW-1:0] d);
        @(negedge clk); reg_addr = a; reg_rd = 1'b1; #1 d = reg_rdata;
        @(negedge clk); reg_rd = 1'b0;
    endtask

    task automatic pulse(logic [NTICK-1:0] t, int n);
        @(negedge clk); tick_en = t;
        repeat (n) @(negedge clk);
        tick_en = '0;
    endtask

    task automatic clr_status(logic [NCH-1:0] m);
        @(negedge clk); status_clr = m;
        @(negedge clk); status_clr = '0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        finish_run();
    end

    initial begin
        logic [CW-1:0] d, exp;
        void'($urandom(32'd4711));
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd(a_cnt(3), d);   check("R1 counter", d, 0);
        rd(a_match(6), d); check("R1 match", d, 0);
        rd(a_ctrl(5), d);  check("R1 control", d, 0);
        rd(8'h20, d);      check("R1 snapshot", d, 0);
        check("R1 status", CW'(status), 0);
        check("R1 irq", CW'(irq), 0);

        // R3 direct load
        wr(a_cnt(2), 32'h1234_5678); rd(a_cnt(2), d); check("R3 load", d, 32'h1234_5678);
        wr(a_cnt(7), 32'hFFFF_FFFF); rd(a_cnt(7), d); check("R3 load max", d, 32'hFFFF_FFFF);

        // R2 directed: code 1 picks tick_en[0], others ignored; off codes hold
        wr(a_ctrl(0), 32'h81); wr(a_cnt(0), 0);
        pulse(5'b00001, 5);  rd(a_cnt(0), d); check("R2 count", d, 5);
        pulse(5'b11110, 4);  rd(a_cnt(0), d); check("R2 other rates", d, 5);
        wr(a_ctrl(0), 32'h80); pulse(5'b11111, 3); rd(a_cnt(0), d); check("R2 code0 hold", d, 5);
        wr(a_ctrl(0), 32'h86); pulse(5'b11111, 3); rd(a_cnt(0), d); check("R2 code6 hold", d, 5);
        wr(a_ctrl(0), 32'h81); wr(a_cnt(0), 32'hFFFF_FFFF);
        pulse(5'b00001, 1); rd(a_cnt(0), d); check("R2 wrap", d, 0);

        // R2 random rate patterns
        for (int rep = 0; rep < 12; rep++) begin
            int s;
            s = 1 + int'($urandom % 5);
            exp = $urandom;
            wr(a_ctrl(1), CW'(32'h80 | s));
            wr(a_cnt(1), exp);
            for (int c = 0; c < 20; c++) begin
                logic [NTICK-1:0] t;
                t = NTICK'($urandom);
                @(negedge clk); tick_en = t;
                if (t[s-1]) exp = exp + 1;
            end
            @(negedge clk); tick_en = '0;
            rd(a_cnt(1), d); check("R2 random", d, exp);
        end

        // R4 masks and rate block
        wr(a_ctrl(1), 32'hFFF); rd(a_ctrl(1), d); check("R4 low mask", d, 32'hFF);
        wr(a_ctrl(5), 32'hFFF); rd(a_ctrl(5), d); check("R4 high mask", d, 32'h3FF);
        wr(a_ctrl(5), 32'h181); wr(a_cnt(5), 10);
        pulse(5'b00001, 4); rd(a_cnt(5), d); check("R4 blocked", d, 10);
        wr(a_ctrl(5), 32'h81);
        pulse(5'b00001, 4); rd(a_cnt(5), d); check("R4 unblocked", d, 14);

        // R5 shared counter, R6 status and irq
        wr(a_ctrl(0), 32'h81); wr(a_cnt(0), 100);
        wr(a_ctrl(2), 32'h01); wr(a_cnt(2), 7); wr(a_match(2), 103);
        irq_en = 8'h04;
        pulse(5'b00001, 2);
        check("R5 not yet", CW'(status[2]), 0);
        rd(a_cnt(2), d); check("R5 follower stopped", d, 7);
        pulse(5'b00001, 1);
        check("R6 status set", CW'(status[2]), 1);
        check("R6 irq", CW'(irq), 1);
        rd(a_cnt(2), d); check("R5 follower still", d, 7);

        // R9 clear
        clr_status(8'h04);
        check("R9 cleared", CW'(status), 0);
        check("R9 irq low", CW'(irq), 0);

        // R6 disabled channel does not set status
        wr(a_ctrl(4), 32'h81); wr(a_cnt(4), 0); wr(a_match(4), 3);
        pulse(5'b00001, 3);
        check("R6 masked", CW'(status[4]), 0);

        // R8 one-shot stays silent, R11 rearm
        irq_en = 8'h10;
        wr(a_cnt(4), 0); pulse(5'b00001, 3);
        check("R8 oneshot silent", CW'(status[4]), 0);
        wr(a_match(4), 3); wr(a_cnt(4), 0); pulse(5'b00001, 3);
        check("R11 rearmed", CW'(status[4]), 1);

        // R7 clear on match, R8 periodic
        irq_en = 8'h50;
        wr(a_ctrl(6), 32'hC9); wr(a_cnt(6), 0); wr(a_match(6), 4);
        pulse(5'b00001, 4);
        check("R8 periodic first", CW'(status[6]), 1);
        rd(a_cnt(6), d); check("R7 cleared", d, 0);
        clr_status(8'h10);
        check("R9 irq held", CW'(irq), 1);
        clr_status(8'h40);
        check("R9 irq dropped", CW'(irq), 0);
        pulse(5'b00001, 4);
        check("R8 periodic again", CW'(status[6]), 1);
        clr_status(8'h40);
        wr(a_ctrl(6), 32'h89); wr(a_cnt(6), 0);
        pulse(5'b00001, 4);
        check("R8 oneshot fires", CW'(status[6]), 1);
        clr_status(8'h40);
        pulse(5'b00001, 4);
        check("R8 oneshot once", CW'(status[6]), 0);
        rd(a_cnt(6), d); check("R7 no hit no clear", d, 4);

        // R10 snapshot
        wr(a_ctrl(4), 32'h80); wr(a_cnt(4), 32'h55);
        wr(a_ctrl(5), 32'h280);
        rd(a_cnt(5), d); rd(8'h20, d); check("R10 capture 4", d, 32'h55);
        wr(a_cnt(4), 32'h66); wr(a_ctrl(5), 32'h080);
        rd(a_cnt(5), d); rd(8'h20, d); check("R10 no capture", d, 32'h55);
        wr(a_ctrl(6), 32'h80); wr(a_cnt(6), 32'h77); wr(a_ctrl(7), 32'h280);
        rd(a_cnt(7), d); rd(8'h20, d); check("R10 capture 6", d, 32'h77);

        finish_run();
    end
endmodule